// File: doc/BRIEF.md
# Two-Key Register Write Unlock

This block protects a peripheral's register file against stray writes. Two kick registers are set aside for it. These two registers can always be written. Every other register accepts a write only after the correct pair of 32-bit keys has arrived, in order: the first key to the first kick register, then the second key to the second. The block watches the bus write strobe, one select line for each kick register, and the write data. It produces a qualified write enable for the protected registers and a status bit that shows whether they are currently open.

Any later write to either kick register closes the protection again. It closes on the next edge, whatever value was written. This lets software relock the registers with a single store after it finishes a configuration sequence.

Top module: `write_unlock_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the block is locked: `unlocked` is 0 and `protWrEn` is 0 even when `wrStrobe` is 1.
- R2: When locked, a strobed write with only `selKeyA` high and data 0x83E70B13 moves the block to an armed state. `unlocked` stays 0.
- R3: When armed, a strobed write with only `selKeyB` high and data 0x95A4F1E0 opens the block. `unlocked` reads 1 from the next cycle on.
- R4: When locked, a strobed write to the first kick register with any other value, or any strobed write to the second kick register, leaves the block locked. A correct second key sent afterwards does not open it.
- R5: When armed, a strobed write to the second kick register with a wrong value returns the block to locked.
- R6: When armed, a strobed write of any value to the first kick register, the first key included, returns the block to locked.
- R7: When open, a strobed write of any value to either kick register locks the block on the next edge.
- R8: `protWrEn` is combinationally `wrStrobe` AND open AND neither kick select high. A write that hits a kick register never enables a protected write in that same cycle.
- R9: Select lines high without `wrStrobe` have no effect on the lock state.
- R10: A strobed write with both kick selects high at once sends the block to locked from any state.
- R11: When armed, strobed writes that hit no kick register keep the block armed. `protWrEn` stays 0 for those writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrStrobe | input | 1 | Bus write strobe |
| selKeyA | input | 1 | Address select of the first kick register |
| selKeyB | input | 1 | Address select of the second kick register |
| wrData | input | DATA_W | Bus write data |
| protWrEn | output | 1 | Write enable qualifier for protected registers |
| unlocked | output | 1 | 1 when protected registers are open |

## Verification
On every cycle, the assertions check these properties:
- A kick hit never lets a protected write through.
- An open state is only ever entered from the armed state on a correct second-key write.
- Kick writes in the open state relock the block.
- The locked state is not left without the first key.

The armed state cannot be seen at the ports. Only the bench's scenarios show it, by following a correct or incorrect first step with a second key and observing whether `unlocked` rises. The same scenarios show that strobeless selects and intervening ordinary writes leave the sequence intact.

// File: rtl/wug_pkg.sv
package wug_pkg;
  typedef enum logic [1:0] {
    LOCKED = 2'd0,
    ARMED  = 2'd1,
    OPEN   = 2'd2
  } lockState_e;

  // Strobes from the key datapath to the lock control.
  typedef struct packed {
    logic hitA;
    logic hitB;
    logic keyAOk;
    logic keyBOk;
  } kickStrobe_t;
endpackage

// File: rtl/wug_kick_decode.sv
module wug_kick_decode
  import wug_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY_A = 'h83E70B13,
  parameter logic [DATA_W-1:0] KEY_B = 'h95A4F1E0
) (
  input  logic              wrStrobe,
  input  logic              selKeyA,
  input  logic              selKeyB,
  input  logic [DATA_W-1:0] wrData,
  input  logic              isOpen,
  output kickStrobe_t       strobes,
  output logic              kickHit,
  output logic              protWrEn
);
  localparam int unsigned NUM_KEYS = 2;

  logic [NUM_KEYS-1:0] keyMatch;
  logic [NUM_KEYS-1:0] selVec;
  logic [DATA_W-1:0]   keyTable [NUM_KEYS];

  assign keyTable[0] = KEY_A;
  assign keyTable[1] = KEY_B;
  assign selVec      = {selKeyB, selKeyA};

  // One comparator per kick register.
  for (genvar k = 0; k < NUM_KEYS; k++) begin : gKeyCmp
    assign keyMatch[k] = (wrData == keyTable[k]);
  end

  always_comb begin
    strobes.hitA   = wrStrobe & selVec[0];
    strobes.hitB   = wrStrobe & selVec[1];
    strobes.keyAOk = keyMatch[0];
    strobes.keyBOk = keyMatch[1];
    kickHit        = |selVec;
    protWrEn       = wrStrobe & isOpen & ~kickHit;
  end
endmodule

// File: rtl/wug_lock_fsm.sv
module wug_lock_fsm
  import wug_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  kickStrobe_t strobes,
  output logic        isOpen
);
  lockState_e stateQ, stateD;
  logic anyHit;

  assign anyHit = strobes.hitA | strobes.hitB;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      LOCKED: if (strobes.hitA && !strobes.hitB && strobes.keyAOk) stateD = ARMED;
      ARMED: begin
        if (strobes.hitB && !strobes.hitA && strobes.keyBOk) stateD = OPEN;
        else if (anyHit) stateD = LOCKED;
      end
      OPEN:    if (anyHit) stateD = LOCKED;
      default: stateD = LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= LOCKED;
    else       stateQ <= stateD;
  end

  assign isOpen = (stateQ == OPEN);

  assert_open_only_from_key_b_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isOpen) |-> $past(stateQ == ARMED && strobes.hitB && !strobes.hitA && strobes.keyBOk));

  assert_open_relocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == OPEN && anyHit) |=> (stateQ == LOCKED));

  assert_locked_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == LOCKED && !(strobes.hitA && !strobes.hitB && strobes.keyAOk)) |=> (stateQ == LOCKED));

  assert_armed_abort_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ARMED && strobes.hitA) |=> (stateQ == LOCKED));

  assert_armed_wrong_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ARMED && strobes.hitB && !strobes.keyBOk) |=> (stateQ == LOCKED));
endmodule

// File: rtl/write_unlock_guard.sv
module write_unlock_guard
  import wug_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY_A = 'h83E70B13,
  parameter logic [DATA_W-1:0] KEY_B = 'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic              selKeyA,
  input  logic              selKeyB,
  input  logic [DATA_W-1:0] wrData,
  output logic              protWrEn,
  output logic              unlocked
);
  kickStrobe_t strobes;
  logic kickHit;
  logic isOpen;

  wug_kick_decode #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) uDecode (
    .wrStrobe(wrStrobe), .selKeyA(selKeyA), .selKeyB(selKeyB), .wrData(wrData),
    .isOpen(isOpen), .strobes(strobes), .kickHit(kickHit), .protWrEn(protWrEn)
  );

  wug_lock_fsm uFsm (
    .clk(clk), .rstN(rstN), .strobes(strobes), .isOpen(isOpen)
  );

  assign unlocked = isOpen;

  assert_kick_blocks_prot_R8: assert property (@(posedge clk) disable iff (!rstN)
    kickHit |-> !protWrEn);

  assert_prot_needs_open_R8: assert property (@(posedge clk) disable iff (!rstN)
    protWrEn |-> (unlocked && wrStrobe));

  assert_no_strobe_no_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |=> $stable(unlocked));
endmodule

// File: tb/write_unlock_guard_test.sv
module write_unlock_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY_A = 32'h83E70B13;
  localparam logic [31:0] KEY_B = 32'h95A4F1E0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStrobe = 1'b0, selKeyA = 1'b0, selKeyB = 1'b0;
  logic [31:0] wrData = '0;
  logic protWrEn, unlocked;

  int checks = 0;
  int errors = 0;
  int mState = 0; // 0 locked, 1 armed, 2 open
  bit finished = 1'b0;

  write_unlock_guard uut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .selKeyA(selKeyA),
    .selKeyB(selKeyB), .wrData(wrData), .protWrEn(protWrEn), .unlocked(unlocked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int nextSt(int s, bit w, bit a, bit b, logic [31:0] d);
    bit ha = w & a;
    bit hb = w & b;
    case (s)
      0: return (ha && !hb && d == KEY_A) ? 1 : 0;
      1: begin
        if (hb && !ha && d == KEY_B) return 2;
        if (ha || hb) return 0;
        return 1;
      end
      default: return (ha || hb) ? 0 : 2;
    endcase
  endfunction

  function automatic string reqTag(int s, bit w, bit a, bit b, logic [31:0] d);
    if (!w && (a || b)) return "R9";
    if (w && a && b) return "R10";
    case (s)
      0: if (w && a && d == KEY_A) return "R2"; else if (w && (a || b)) return "R4"; else return "R8";
      1: if (w && b && d == KEY_B) return "R3"; else if (w && b) return "R5";
         else if (w && a) return "R6"; else return "R11";
      default: return (w && (a || b)) ? "R7" : "R8";
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(bit w, bit a, bit b, logic [31:0] d);
    string tag;
    @(negedge clk);
    wrStrobe = w; selKeyA = a; selKeyB = b; wrData = d;
    tag = reqTag(mState, w, a, b, d);
    #1;
    check(tag, protWrEn, w && !a && !b && mState == 2, "protWrEn");
    check(tag, unlocked, mState == 2, "unlocked");
    @(posedge clk);
    mState = nextSt(mState, w, a, b, d);
  endtask

  task automatic idleCheck(string req);
    step(1'b0, 1'b0, 1'b0, 32'h0);
    @(negedge clk); #1;
    check(req, unlocked, mState == 2, "unlocked after sequence");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state, strobe held high
    wrStrobe = 1'b1;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R1", unlocked, 1'b0, "unlocked in reset");
    check("R1", protWrEn, 1'b0, "protWrEn in reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1", unlocked, 1'b0, "unlocked after reset");
    check("R1", protWrEn, 1'b0, "protWrEn after reset");
    wrStrobe = 1'b0;

    // R2, R3: good sequence, then R8 protected write, R7 relock
    step(1, 1, 0, KEY_A); step(1, 0, 1, KEY_B); idleCheck("R3");
    step(1, 0, 0, 32'h1234); step(1, 0, 1, 32'h0); idleCheck("R7");
    // R4: wrong first key then second key
    step(1, 1, 0, KEY_A ^ 32'h1); step(1, 0, 1, KEY_B); idleCheck("R4");
    // R4: second key first
    step(1, 0, 1, KEY_B); step(1, 0, 1, KEY_B); idleCheck("R4");
    // R5: wrong second key
    step(1, 1, 0, KEY_A); step(1, 0, 1, KEY_A); step(1, 0, 1, KEY_B); idleCheck("R5");
    // R6: first key twice
    step(1, 1, 0, KEY_A); step(1, 1, 0, KEY_A); step(1, 0, 1, KEY_B); idleCheck("R6");
    // R9 and R11: intervening strobeless selects and ordinary writes keep armed
    step(1, 1, 0, KEY_A); step(0, 1, 1, 32'h0); step(1, 0, 0, KEY_B);
    step(1, 0, 1, KEY_B); idleCheck("R11");
    // R7 with first key value
    step(1, 1, 0, KEY_A); idleCheck("R7");
    // R10: both selects
    step(1, 1, 0, KEY_A); step(1, 1, 1, KEY_B); step(1, 0, 1, KEY_B); idleCheck("R10");
    step(1, 1, 1, KEY_A); step(1, 0, 1, KEY_B); idleCheck("R10");

    // Random mix, biased toward keys
    for (int i = 0; i < 3000; i++) begin
      bit w = ($urandom_range(0, 9) != 0);
      bit a = ($urandom_range(0, 2) == 0);
      bit b = ($urandom_range(0, 2) == 0);
      int pick = $urandom_range(0, 3);
      logic [31:0] d = (pick == 0) ? KEY_A : (pick == 1) ? KEY_B : $urandom;
      if (mState == 1 && $urandom_range(0, 1) == 1) begin w = 1; a = 0; b = 1; d = KEY_B; end
      step(w, a, b, d);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule